// File: doc/BRIEF.md
# ADC conversion sequencing controller

This block sets the timing of conversions for an analog front end. Software loads a 32-bit mode word through a simple write port that a write-protect input can lock. The word sets a clock divider that makes the front-end time base, a startup delay code, a transfer code, a trigger source and the power and sequence policies. A conversion sequence starts from a software pulse, from a rising edge on one of seven hardware trigger lines, or at once in free-run mode. It then steps through every enabled channel.

For each channel the controller first waits a startup delay, but only when the front end was powered off. It then waits a transfer period, drives the channel select, and holds a tracking window of 15 time-base ticks. It then pulses a start-of-conversion strobe. The analog converter is modelled by a fixed wait of `CONV_TICKS` ticks, after which a done pulse is raised. When the last channel has finished, the power policy decides which supplies stay on.

Top module: `adc_seq_ctrl`

## Requirements
- R1: Out of reset the read-back word is 0x30800000, `busy`, `afe_pwr` and `ref_pwr` are 0, and a software start does nothing because the divider field is zero.
- R2: While `wprot_en` is 1, writes leave the read-back word unchanged. While it is 0, a write stores `cfg_wdata` exactly, except that bit 23 always reads 1. Bits 27:24 are stored but have no effect on timing.
- R3: The divider field is bits 15:8 (value P). Time-base ticks come every P+1 clocks, counted from the edge that starts the sequence. With P = 0 no sequence can start.
- R4: The startup code in bits 19:16 gives 0, 8, 16, 24, 64, 80, 96, 112, 512, 576, 640, 704, 768, 832, 896 or 960 ticks for codes 0 to 15. The delay applies only when `afe_pwr` is 0 at the start.
- R5: The transfer code in bits 29:28 gives 8 ticks for code 2 and 9 ticks for codes 3, 0 and 1.
- R6: Tracking (`track_en` = 1) lasts 15 ticks. With start edge E0, `conv_start` is a one-cycle pulse set at edge E0+(S+X+15)(P+1), and `conv_done` is a one-cycle pulse set CONV_TICKS(P+1) clocks later (default CONV_TICKS = 4).
- R7: Bit 0 enables hardware triggers and bits 3:1 select line `hw_trig[sel]`. A rising edge on the selected line starts a sequence on the third clock edge after it is sampled. Select code 7, an unselected line, or bit 0 clear give no start. `sw_start` always starts a sequence.
- R8: Starts and trigger edges that arrive while `busy` is 1 are ignored.
- R9: With bit 31 clear, enabled channels are converted in ascending order and `chan_sel` equals the channel index. Consecutive done pulses are (X+15+CONV_TICKS)(P+1) clocks apart.
- R10: With bit 31 set, slot i (enabled by `chan_en[i]`, in ascending slot order) converts the channel in `seq_map[i*CH_W +: CH_W]`.
- R11: After a sequence, bit 6 (fast wakeup) set leaves `afe_pwr`=0 and `ref_pwr`=1. Otherwise bit 5 (sleep) set leaves both at 0, and with both bits clear both stay 1.
- R12: With bit 7 (free-run) set, `busy` is 0 for exactly one cycle after the last done pulse, and the next sequence then starts with no trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Mode word write strobe |
| cfg_wdata | input | 32 | Mode word write data |
| wprot_en | input | 1 | Write-protect enable, blocks writes when 1 |
| cfg_rdata | output | 32 | Stored mode word |
| chan_en | input | NCH | Channel or slot enables |
| seq_map | input | NCH*CH_W | User order, one channel index per slot |
| sw_start | input | 1 | Software start pulse |
| hw_trig | input | NTRIG | Asynchronous hardware trigger lines |
| afe_pwr | output | 1 | Front-end power enable |
| ref_pwr | output | 1 | Reference power enable |
| chan_sel | output | CH_W | Selected analog channel |
| track_en | output | 1 | Tracking window active |
| conv_start | output | 1 | Start-of-conversion strobe |
| conv_done | output | 1 | Conversion done pulse |
| busy | output | 1 | Sequence in progress |

## Verification
A mode write shows on the read-back port one edge later. A software start is taken on the next edge, and a hardware edge is taken on the third edge after it is sampled. After the start edge, `conv_start` is due after (S+X+15)(P+1) edges and `conv_done` after a further CONV_TICKS(P+1) edges, where S and X are the startup and transfer delays in ticks. The bench drives inputs and samples outputs on falling edges. It counts rising edges from the start edge and compares each count with these formulas, using both a vector table and directed cases. Channel order, power policy and free-run restart are checked on the falling edge that follows each done pulse.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int CNT_W       = 10;
    localparam int TRACK_TICKS = 15;

    typedef struct packed {
        logic       useq;
        logic       free;
        logic       fwup;
        logic       sleep;
        logic       trgen;
        logic [2:0] tsel;
        logic [7:0] presc;
        logic [3:0] sut;
        logic [1:0] xfer;
    } mode_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_STUP, ST_XFER, ST_TRACK, ST_CONV
    } seq_st_t;

    function automatic mode_t decode_mode(input logic [31:0] w);
        mode_t m;
        m.useq  = w[31];
        m.xfer  = w[29:28];
        m.sut   = w[19:16];
        m.presc = w[15:8];
        m.free  = w[7];
        m.fwup  = w[6];
        m.sleep = w[5];
        m.tsel  = w[3:1];
        m.trgen = w[0];
        return m;
    endfunction

    function automatic logic [CNT_W-1:0] startup_ticks(input logic [3:0] c);
        logic [CNT_W-1:0] t;
        if (c[3])      t = CNT_W'(512) + (CNT_W'(c[2:0]) << 6);
        else if (c[2]) t = CNT_W'(64) + (CNT_W'(c[1:0]) << 4);
        else           t = CNT_W'(c[1:0]) << 3;
        return t;
    endfunction

    function automatic logic [CNT_W-1:0] xfer_ticks(input logic [1:0] c);
        return (c == 2'd2) ? CNT_W'(8) : CNT_W'(9);
    endfunction

endpackage

// File: rtl/adc_mode_reg.sv
module adc_mode_reg
    import adc_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic [31:0] cfg_wdata,
    input  logic        wprot_en,
    output logic [31:0] cfg_rdata,
    output mode_t       mode
);
    localparam logic [31:0] RESET_WORD = 32'h3080_0000;
    localparam logic [31:0] FIXED_ONE  = 32'h0080_0000;

    always_ff @(posedge clk) begin
        if (rst)
            cfg_rdata <= RESET_WORD;
        else if (cfg_we && !wprot_en)
            cfg_rdata <= cfg_wdata | FIXED_ONE;
    end

    assign mode = decode_mode(cfg_rdata);

    p_wp_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && wprot_en) |=> $stable(cfg_rdata));

endmodule

// File: rtl/adc_trig_sync.sv
module adc_trig_sync #(
    parameter int NTRIG = 7,
    parameter int SYNC  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NTRIG-1:0] hw_trig,
    input  logic             trgen,
    input  logic [2:0]       tsel,
    output logic             trig_pulse
);
    logic [NTRIG-1:0] edg;

    for (genvar g = 0; g < NTRIG; g++) begin : g_line
        logic [SYNC-1:0] sr;
        logic            dly;
        always_ff @(posedge clk) begin
            if (rst) begin
                sr  <= '0;
                dly <= 1'b0;
            end else begin
                sr  <= {sr[SYNC-2:0], hw_trig[g]};
                dly <= sr[SYNC-1];
            end
        end
        assign edg[g] = sr[SYNC-1] & ~dly;
    end

    always_comb begin
        trig_pulse = 1'b0;
        for (int i = 0; i < NTRIG; i++)
            if (trgen && tsel == 3'(i) && edg[i]) trig_pulse = 1'b1;
    end

endmodule

// File: rtl/adc_tick_gen.sv
module adc_tick_gen (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic [7:0] presc,
    output logic       tick
);
    logic [7:0] cnt;

    assign tick = run && (presc != 8'd0) && (cnt == presc);

    always_ff @(posedge clk) begin
        if (rst || !run || tick) cnt <= 8'd0;
        else                     cnt <= cnt + 8'd1;
    end

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int NCH        = 8,
    parameter int CH_W       = 3,
    parameter int CONV_TICKS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_req,
    input  logic              presc_nz,
    input  logic              tick,
    input  logic              useq,
    input  logic              fwup,
    input  logic              sleep,
    input  logic [3:0]        sut,
    input  logic [1:0]        xfer,
    input  logic [NCH-1:0]    chan_en,
    input  logic [NCH*CH_W-1:0] seq_map,
    output logic              afe_pwr,
    output logic              ref_pwr,
    output logic [CH_W-1:0]   chan_sel,
    output logic              track_en,
    output logic              conv_start,
    output logic              conv_done,
    output logic              busy
);
    seq_st_t          st;
    logic [CNT_W-1:0] rem;
    logic [CH_W-1:0]  idx, first_idx, next_idx, cur_chan;
    logic             has_first, has_next, last, start_ok;

    always_comb begin
        has_first = 1'b0;
        first_idx = '0;
        has_next  = 1'b0;
        next_idx  = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (chan_en[i]) begin
                has_first = 1'b1;
                first_idx = CH_W'(i);
                if (i > int'(idx)) begin
                    has_next = 1'b1;
                    next_idx = CH_W'(i);
                end
            end
        end
        cur_chan = useq ? seq_map[int'(idx)*CH_W +: CH_W] : idx;
    end

    assign last     = tick && (rem == CNT_W'(1));
    assign start_ok = start_req && presc_nz && has_first;
    assign track_en = (st == ST_TRACK);
    assign busy     = (st != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            rem        <= '0;
            idx        <= '0;
            afe_pwr    <= 1'b0;
            ref_pwr    <= 1'b0;
            chan_sel   <= '0;
            conv_start <= 1'b0;
            conv_done  <= 1'b0;
        end else begin
            conv_start <= 1'b0;
            conv_done  <= 1'b0;
            if (tick) rem <= rem - CNT_W'(1);
            case (st)
                ST_IDLE: if (start_ok) begin
                    idx     <= first_idx;
                    afe_pwr <= 1'b1;
                    ref_pwr <= 1'b1;
                    if (!afe_pwr && sut != 4'd0) begin
                        st  <= ST_STUP;
                        rem <= startup_ticks(sut);
                    end else begin
                        st  <= ST_XFER;
                        rem <= xfer_ticks(xfer);
                    end
                end
                ST_STUP: if (last) begin
                    st  <= ST_XFER;
                    rem <= xfer_ticks(xfer);
                end
                ST_XFER: if (last) begin
                    st       <= ST_TRACK;
                    rem      <= CNT_W'(TRACK_TICKS);
                    chan_sel <= cur_chan;
                end
                ST_TRACK: if (last) begin
                    st         <= ST_CONV;
                    rem        <= CNT_W'(CONV_TICKS);
                    conv_start <= 1'b1;
                end
                ST_CONV: if (last) begin
                    conv_done <= 1'b1;
                    if (has_next) begin
                        idx <= next_idx;
                        st  <= ST_XFER;
                        rem <= xfer_ticks(xfer);
                    end else begin
                        st <= ST_IDLE;
                        if (fwup) begin
                            afe_pwr <= 1'b0;
                        end else if (sleep) begin
                            afe_pwr <= 1'b0;
                            ref_pwr <= 1'b0;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    p_soc_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        conv_start |=> !conv_start);
    p_track_end_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(track_en) |-> conv_start);
    p_pwr_track_r11: assert property (@(posedge clk) disable iff (rst)
        track_en |-> (afe_pwr && ref_pwr));
    p_start_gate_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(presc_nz));

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int NCH        = 8,
    parameter int NTRIG      = 7,
    parameter int SYNC       = 2,
    parameter int CONV_TICKS = 4,
    localparam int CH_W      = $clog2(NCH)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [31:0]         cfg_wdata,
    input  logic                wprot_en,
    output logic [31:0]         cfg_rdata,
    input  logic [NCH-1:0]      chan_en,
    input  logic [NCH*CH_W-1:0] seq_map,
    input  logic                sw_start,
    input  logic [NTRIG-1:0]    hw_trig,
    output logic                afe_pwr,
    output logic                ref_pwr,
    output logic [CH_W-1:0]     chan_sel,
    output logic                track_en,
    output logic                conv_start,
    output logic                conv_done,
    output logic                busy
);
    mode_t mode;
    logic  trig_pulse, tick, start_req;

    adc_mode_reg u_mode (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .wprot_en(wprot_en), .cfg_rdata(cfg_rdata), .mode(mode)
    );

    adc_trig_sync #(.NTRIG(NTRIG), .SYNC(SYNC)) u_trig (
        .clk(clk), .rst(rst), .hw_trig(hw_trig), .trgen(mode.trgen),
        .tsel(mode.tsel), .trig_pulse(trig_pulse)
    );

    adc_tick_gen u_tick (
        .clk(clk), .rst(rst), .run(busy), .presc(mode.presc), .tick(tick)
    );

    assign start_req = sw_start | trig_pulse | mode.free;

    adc_seq_fsm #(.NCH(NCH), .CH_W(CH_W), .CONV_TICKS(CONV_TICKS)) u_fsm (
        .clk(clk), .rst(rst), .start_req(start_req),
        .presc_nz(mode.presc != 8'd0), .tick(tick), .useq(mode.useq),
        .fwup(mode.fwup), .sleep(mode.sleep), .sut(mode.sut), .xfer(mode.xfer),
        .chan_en(chan_en), .seq_map(seq_map), .afe_pwr(afe_pwr),
        .ref_pwr(ref_pwr), .chan_sel(chan_sel), .track_en(track_en),
        .conv_start(conv_start), .conv_done(conv_done), .busy(busy)
    );

endmodule

// File: tb/adc_seq_ctrl_tb_top.sv
module adc_seq_ctrl_tb_top;
    localparam int NCH = 8, NTRIG = 7, CH_W = 3;

    logic clk = 1'b0, rst = 1'b1;
    logic cfg_we = 1'b0, wprot_en = 1'b0, sw_start = 1'b0;
    logic [31:0] cfg_wdata = '0, cfg_rdata;
    logic [NCH-1:0] chan_en = '0;
    logic [NCH*CH_W-1:0] seq_map = '0;
    logic [NTRIG-1:0] hw_trig = '0;
    logic afe_pwr, ref_pwr, track_en, conv_start, conv_done, busy;
    logic [CH_W-1:0] chan_sel;
    int n_chk = 0, n_fail = 0;

    always #5 clk = ~clk;

    adc_seq_ctrl dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .wprot_en(wprot_en), .cfg_rdata(cfg_rdata), .chan_en(chan_en),
        .seq_map(seq_map), .sw_start(sw_start), .hw_trig(hw_trig),
        .afe_pwr(afe_pwr), .ref_pwr(ref_pwr), .chan_sel(chan_sel),
        .track_en(track_en), .conv_start(conv_start), .conv_done(conv_done),
        .busy(busy)
    );

    typedef struct packed {
        logic [7:0] p; logic [3:0] su; logic [1:0] xf;
        logic [15:0] soc; logic [15:0] dn;
    } vec_t;
    // soc = (S + X + 15) * (P + 1), done = soc + 4 * (P + 1)
    localparam vec_t TBL [7] = '{
        '{8'd1, 4'd0,  2'd2, 16'd46,   16'd54},
        '{8'd1, 4'd1,  2'd3, 16'd64,   16'd72},
        '{8'd2, 4'd2,  2'd0, 16'd120,  16'd132},
        '{8'd3, 4'd4,  2'd1, 16'd352,  16'd368},
        '{8'd1, 4'd8,  2'd2, 16'd1070, 16'd1078},
        '{8'd4, 4'd3,  2'd3, 16'd240,  16'd260},
        '{8'd1, 4'd15, 2'd3, 16'd1968, 16'd1976}
    };

    function automatic logic [31:0] mk(bit us, logic [1:0] xf, logic [3:0] su,
        logic [7:0] p, bit fr, bit fw, bit sl, logic [2:0] sel, bit te);
        return {us, 1'b0, xf, 4'hF, 1'b0, 3'b0, su, p, fr, fw, sl, 1'b0, sel, te};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [31:0] v);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic kick();
        @(negedge clk); sw_start = 1'b1;
        @(negedge clk); sw_start = 1'b0;
    endtask

    task automatic measure(output int ns, output int nd);
        int n = 0;
        ns = -1; nd = -1;
        while (nd < 0 && n < 5000) begin
            @(posedge clk); n++;
            @(negedge clk);
            if (conv_start && ns < 0) ns = n;
            if (conv_done) nd = n;
        end
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 5000) begin @(negedge clk); n++; end
    endtask

    task automatic expect_idle(int cyc, string tag);
        int seen = 0;
        for (int i = 0; i < cyc; i++) begin @(negedge clk); if (busy) seen++; end
        chk(tag, seen, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        int ns, nd, t0, gap;
        logic [CH_W-1:0] c0, c1, c2;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset word", cfg_rdata, 32'h3080_0000);
        chk("R1 reset busy/pwr", {busy, afe_pwr, ref_pwr}, 0);
        chan_en = 8'b0000_0001;
        kick();
        expect_idle(20, "R1 zero divider blocks start");

        wprot_en = 1'b1;
        wr(mk(0, 2'd2, 4'd1, 8'd1, 0, 0, 0, 3'd0, 0));
        chk("R2 protected write ignored", cfg_rdata, 32'h3080_0000);
        wprot_en = 1'b0;
        wr(mk(0, 2'd0, 4'd1, 8'd1, 0, 0, 1, 3'd0, 0));
        chk("R2 R5 readback with bit23", cfg_rdata,
            mk(0, 2'd0, 4'd1, 8'd1, 0, 0, 1, 3'd0, 0) | 32'h0080_0000);

        for (int v = 0; v < 7; v++) begin
            wr(mk(0, TBL[v].xf, TBL[v].su, TBL[v].p, 0, 0, 1, 3'd0, 0));
            kick();
            measure(ns, nd);
            chk($sformatf("R4 R5 R6 R3 soc vec%0d", v), ns, TBL[v].soc);
            chk($sformatf("R6 R3 done vec%0d", v), nd, TBL[v].dn);
            wait_idle();
        end
        @(negedge clk);
        chk("R11 sleep powers off", {afe_pwr, ref_pwr}, 2'b00);

        wr(mk(0, 2'd2, 4'd2, 8'd1, 0, 0, 0, 3'd0, 0));
        kick(); measure(ns, nd);
        chk("R4 cold start soc", ns, 78);
        wait_idle(); @(negedge clk);
        chk("R11 normal keeps power", {afe_pwr, ref_pwr}, 2'b11);
        kick(); measure(ns, nd);
        chk("R4 warm start skips startup", ns, 46);
        wait_idle();

        chan_en = 8'b1010_0100;
        kick();
        for (int k = 0; k < 3; k++) begin
            measure(ns, nd);
            if (k == 0) c0 = chan_sel; else if (k == 1) c1 = chan_sel; else c2 = chan_sel;
            if (k == 1) gap = nd;
        end
        chk("R9 numeric order", {c0, c1, c2}, {3'd2, 3'd5, 3'd7});
        chk("R9 done spacing", gap, 54);
        wait_idle();

        wr(mk(1, 2'd2, 4'd2, 8'd1, 0, 0, 0, 3'd0, 0));
        chan_en = 8'b0000_0101;
        seq_map = 24'd198;
        kick();
        measure(ns, nd); c0 = chan_sel;
        measure(ns, nd); c1 = chan_sel;
        chk("R10 user order", {c0, c1}, {3'd6, 3'd3});
        wait_idle();

        wr(mk(0, 2'd2, 4'd2, 8'd1, 0, 0, 0, 3'd0, 0));
        chan_en = 8'b0000_0100;
        kick();
        repeat (10) @(negedge clk);
        sw_start = 1'b1; @(negedge clk); sw_start = 1'b0;
        t0 = 0;
        for (int i = 0; i < 150; i++) begin @(negedge clk); if (conv_done) t0++; end
        chk("R8 start while busy ignored: dones", t0, 1);
        chk("R8 start while busy ignored: busy", busy, 0);

        wr(mk(0, 2'd2, 4'd2, 8'd1, 0, 0, 0, 3'd4, 1));
        @(negedge clk); hw_trig[4] = 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R7 trigger not yet taken", busy, 0);
        @(negedge clk);
        chk("R7 trigger taken on third edge", busy, 1);
        wait_idle();
        hw_trig = '0; repeat (4) @(negedge clk);
        hw_trig[3] = 1'b1;
        expect_idle(10, "R7 unselected line");
        hw_trig = '0; repeat (4) @(negedge clk);
        wr(mk(0, 2'd2, 4'd2, 8'd1, 0, 0, 0, 3'd7, 1));
        hw_trig = '1;
        expect_idle(10, "R7 reserved select");
        hw_trig = '0; repeat (4) @(negedge clk);
        wr(mk(0, 2'd2, 4'd2, 8'd1, 0, 0, 0, 3'd4, 0));
        hw_trig[4] = 1'b1;
        expect_idle(10, "R7 hardware disabled");
        hw_trig = '0;

        wr(mk(0, 2'd2, 4'd2, 8'd0, 0, 0, 0, 3'd0, 0));
        kick();
        expect_idle(20, "R3 zero divider");

        wr(mk(0, 2'd2, 4'd2, 8'd1, 0, 1, 0, 3'd0, 0));
        kick(); wait_idle(); @(negedge clk);
        chk("R11 fast wakeup power", {afe_pwr, ref_pwr}, 2'b01);

        wr(mk(0, 2'd2, 4'd0, 8'd1, 1, 0, 0, 3'd0, 0));
        t0 = 0;
        while (!conv_done && t0 < 5000) begin @(negedge clk); t0++; end
        chk("R12 idle one cycle after done", busy, 0);
        @(negedge clk);
        chk("R12 free-run restart", busy, 1);
        wr(mk(0, 2'd2, 4'd0, 8'd1, 0, 0, 0, 3'd0, 0));
        wait_idle();
        expect_idle(10, "R12 stops when free-run cleared");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule